// File: doc/BRIEF.md
# Color filter array gain sequencer

This block sits in an image sensor front end. It decides which of four shared gain/offset register pairs applies to each pixel of a line. Software fills two line-pattern registers and one pattern-length register through a simple write port. Each line-pattern register lists up to four 2-bit slot selectors, one per color position. The length register gives how many of those positions repeat on each of the two line types.

The user raises a beginning-of-line strobe for the length of a line. While it is high, the block walks the active pattern one position per accepted pixel and wraps back to the first position after the last programmed one. Every new line switches to the other line pattern: line 0, line 1, line 0, and so on. Each line starts again from its first position.

The per-pixel result leaves on a valid/ready stream. A pixel counts as accepted when valid and ready are both high. While ready is low the position holds, so the same selector and addresses stay on the outputs. The valid signal follows the strobe in the same cycle, so the downstream side never sees a selector outside a line. Configuration written during a line is staged and only takes hold at the next line start.

Top module: `cfa_gain_seq`

## Requirements
- R1: After reset, `px_valid` is 0 and all staged registers hold 0. The first line after reset uses line pattern 0.
- R2: A write with `cfg_wr_en` high stores `cfg_wr_data` according to `cfg_wr_addr`: address 0 is line pattern 0, address 1 is line pattern 1, address 2 is the length register, and address 3 is ignored.
- R3: In a line pattern register, the selector for position p occupies bits 2p+1:2p, so position 0 is in bits 1:0.
- R4: Length register bits 1:0 give line 0's pattern length minus one, and bits 3:2 give line 1's. The position advances by one per accepted pixel and wraps to 0 after reaching that value, so a value of 0 repeats position 0.
- R5: `px_gain_addr` equals selector + 1 and `px_offset_addr` equals selector + 5.
- R6: A rising `bol` sampled at a clock edge starts a line, and the first pixel is valid in the following cycle. `px_valid` is low in any cycle where `bol` is low.
- R7: Successive lines alternate between line pattern 0 and line pattern 1. Each line starts at position 0. `px_line` reports the pattern in use.
- R8: A configuration write takes effect at the first line start on a later clock edge. A write on the same edge as a line start does not affect that line.
- R9: While `px_valid` is high and `px_ready` is low, the position and all pixel outputs hold.
- R10: A line ends when `bol` is sampled low at a clock edge. A later high `bol` starts the next line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 2 | Configuration register index |
| cfg_wr_data | input | 8 | Configuration write data |
| bol | input | 1 | Beginning-of-line strobe, held high for the line |
| px_ready | input | 1 | Downstream accepts the current pixel |
| px_valid | output | 1 | Pixel outputs are meaningful |
| px_sel | output | 2 | Gain/offset slot selector for this pixel |
| px_gain_addr | output | 4 | Address of the selected gain register |
| px_offset_addr | output | 4 | Address of the selected offset register |
| px_line | output | 1 | Line pattern in use (0 or 1) |

## Verification
A line start is due one clock after the edge that samples `bol` rising. From then on, each accepted pixel moves the outputs by one position at the next edge. `px_valid` falls in the same cycle that `bol` falls, and a write changes nothing until a line start on a later edge. The bench drives inputs just after the falling edge and compares every output 1 ns later, against a behavioural model that is stepped only at rising edges. Each comparison therefore sees exactly the state that the registers have just reached.

// File: rtl/cfa_seq_pkg.sv
package cfa_seq_pkg;
  typedef enum logic [1:0] {
    CFG_LINE0 = 2'd0,
    CFG_LINE1 = 2'd1,
    CFG_LEN   = 2'd2,
    CFG_NONE  = 2'd3
  } cfg_addr_e;
endpackage

// File: rtl/cfa_cfg_regs.sv
module cfa_cfg_regs #(
  parameter int SEL_W = 2,
  parameter int N_POS = 4,
  localparam int PAT_W = SEL_W * N_POS,
  localparam int CNT_W = (N_POS > 1) ? $clog2(N_POS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [1:0]            wr_addr,
  input  logic [PAT_W-1:0]      wr_data,
  output logic [1:0][PAT_W-1:0] pat_o,
  output logic [1:0][CNT_W-1:0] cnt_o
);
  import cfa_seq_pkg::*;

  cfg_addr_e addr_e;
  assign addr_e = cfg_addr_e'(wr_addr);

  // staged copies of both line types, one generated slice per line
  for (genvar ln = 0; ln < 2; ln++) begin : g_line
    logic [PAT_W-1:0] pat_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pat_hit;

    assign pat_hit = wr_en && (addr_e == ((ln == 0) ? CFG_LINE0 : CFG_LINE1));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pat_q <= '0;
        cnt_q <= '0;
      end else begin
        if (pat_hit) pat_q <= wr_data;
        if (wr_en && addr_e == CFG_LEN) cnt_q <= wr_data[ln*CNT_W +: CNT_W];
      end
    end

    assign pat_o[ln] = pat_q;
    assign cnt_o[ln] = cnt_q;
  end
endmodule

// File: rtl/cfa_line_ctrl.sv
module cfa_line_ctrl #(
  parameter int SEL_W = 2,
  parameter int N_POS = 4,
  localparam int PAT_W = SEL_W * N_POS,
  localparam int CNT_W = (N_POS > 1) ? $clog2(N_POS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bol,
  input  logic                  ready,
  input  logic [1:0][PAT_W-1:0] pat_i,
  input  logic [1:0][CNT_W-1:0] cnt_i,
  output logic                  valid,
  output logic                  line,
  output logic [CNT_W-1:0]      pos,
  output logic [PAT_W-1:0]      act_pat
);
  logic             in_line_q;
  logic             next_line_q;
  logic             line_q;
  logic [CNT_W-1:0] pos_q;
  logic [CNT_W-1:0] act_cnt_q;
  logic [PAT_W-1:0] act_pat_q;
  logic             start;
  logic             stop;
  logic             step;

  assign start = bol && !in_line_q;
  assign stop  = in_line_q && !bol;
  assign step  = in_line_q && bol && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_line_q   <= 1'b0;
      next_line_q <= 1'b0;
      line_q      <= 1'b0;
      pos_q       <= '0;
      act_cnt_q   <= '0;
      act_pat_q   <= '0;
    end else if (start) begin
      in_line_q   <= 1'b1;
      line_q      <= next_line_q;
      next_line_q <= ~next_line_q;
      act_pat_q   <= pat_i[next_line_q];
      act_cnt_q   <= cnt_i[next_line_q];
      pos_q       <= '0;
    end else if (stop) begin
      in_line_q   <= 1'b0;
    end else if (step) begin
      pos_q <= (pos_q == act_cnt_q) ? '0 : pos_q + 1'b1;
    end
  end

  assign valid   = in_line_q && bol;
  assign line    = line_q;
  assign pos     = pos_q;
  assign act_pat = act_pat_q;
endmodule

// File: rtl/cfa_sel_map.sv
module cfa_sel_map #(
  parameter int SEL_W  = 2,
  parameter int N_POS  = 4,
  parameter int ADDR_W = 4,
  parameter int GAIN_BASE = 1,
  parameter int OFF_BASE  = 5,
  localparam int PAT_W = SEL_W * N_POS,
  localparam int CNT_W = (N_POS > 1) ? $clog2(N_POS) : 1
) (
  input  logic [PAT_W-1:0]  pat,
  input  logic [CNT_W-1:0]  pos,
  output logic [SEL_W-1:0]  sel,
  output logic [ADDR_W-1:0] gain_addr,
  output logic [ADDR_W-1:0] off_addr
);
  logic [N_POS-1:0][SEL_W-1:0] slot;

  for (genvar p = 0; p < N_POS; p++) begin : g_slot
    assign slot[p] = pat[p*SEL_W +: SEL_W];
  end

  always_comb begin
    sel = slot[0];
    for (int p = 1; p < N_POS; p++) begin
      if (pos == CNT_W'(p)) sel = slot[p];
    end
  end

  assign gain_addr = ADDR_W'(GAIN_BASE) + ADDR_W'(sel);
  assign off_addr  = ADDR_W'(OFF_BASE)  + ADDR_W'(sel);
endmodule

// File: rtl/cfa_gain_seq.sv
module cfa_gain_seq #(
  parameter int SEL_W  = 2,
  parameter int N_POS  = 4,
  parameter int ADDR_W = 4,
  parameter int GAIN_BASE = 1,
  parameter int OFF_BASE  = 5,
  localparam int PAT_W = SEL_W * N_POS,
  localparam int CNT_W = (N_POS > 1) ? $clog2(N_POS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [1:0]        cfg_wr_addr,
  input  logic [PAT_W-1:0]  cfg_wr_data,
  input  logic              bol,
  input  logic              px_ready,
  output logic              px_valid,
  output logic [SEL_W-1:0]  px_sel,
  output logic [ADDR_W-1:0] px_gain_addr,
  output logic [ADDR_W-1:0] px_offset_addr,
  output logic              px_line
);
  logic [1:0][PAT_W-1:0] staged_pat;
  logic [1:0][CNT_W-1:0] staged_cnt;
  logic [CNT_W-1:0]      cur_pos;
  logic [PAT_W-1:0]      cur_pat;

  cfa_cfg_regs #(.SEL_W(SEL_W), .N_POS(N_POS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_addr (cfg_wr_addr),
    .wr_data (cfg_wr_data),
    .pat_o   (staged_pat),
    .cnt_o   (staged_cnt)
  );

  cfa_line_ctrl #(.SEL_W(SEL_W), .N_POS(N_POS)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .bol     (bol),
    .ready   (px_ready),
    .pat_i   (staged_pat),
    .cnt_i   (staged_cnt),
    .valid   (px_valid),
    .line    (px_line),
    .pos     (cur_pos),
    .act_pat (cur_pat)
  );

  cfa_sel_map #(
    .SEL_W(SEL_W), .N_POS(N_POS), .ADDR_W(ADDR_W),
    .GAIN_BASE(GAIN_BASE), .OFF_BASE(OFF_BASE)
  ) u_map (
    .pat       (cur_pat),
    .pos       (cur_pos),
    .sel       (px_sel),
    .gain_addr (px_gain_addr),
    .off_addr  (px_offset_addr)
  );
endmodule

// File: rtl/cfa_gain_seq_chk.sv
module cfa_gain_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bol,
  input logic       px_ready,
  input logic       px_valid,
  input logic [1:0] px_sel,
  input logic [3:0] px_gain_addr,
  input logic [3:0] px_offset_addr,
  input logic       px_line
);
  logic seen_q;
  logic last_line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q      <= 1'b0;
      last_line_q <= 1'b0;
    end else if (px_valid && !$past(px_valid)) begin
      seen_q      <= 1'b1;
      last_line_q <= px_line;
    end
  end

  // R6
  valid_needs_bol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |-> $past(bol));

  // R7
  line_alternates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(px_valid) && seen_q) |-> (px_line != last_line_q));

  // R9
  stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && !px_ready) |=> (!px_valid || ($stable(px_sel) && $stable(px_gain_addr))));

  // R5
  addr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |-> (px_offset_addr == px_gain_addr + 4'd4 && px_gain_addr >= 4'd1 && px_gain_addr <= 4'd4));

  // R1
  first_line_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(px_valid) && !seen_q) |-> (px_line == 1'b0));
endmodule

bind cfa_gain_seq cfa_gain_seq_chk u_chk (.*);

// File: tb/cfa_gain_seq_bench.sv
`timescale 1ns/1ps
module cfa_gain_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic [1:0] cfg_wr_addr = 2'd0;
  logic [7:0] cfg_wr_data = 8'd0;
  logic       bol = 1'b0;
  logic       px_ready = 1'b1;
  logic       px_valid;
  logic [1:0] px_sel;
  logic [3:0] px_gain_addr;
  logic [3:0] px_offset_addr;
  logic       px_line;

  int checks = 0;
  int fails  = 0;

  // reference model state
  int m_pat [2];
  int m_len [2];
  int m_in, m_next, m_line, m_pos, m_apat, m_alen;

  always #10 clk = ~clk;

  cfa_gain_seq u_cfa_gain_seq (.*);

  task automatic model_step();
    if (!rst_n) begin
      m_pat = '{0, 0}; m_len = '{1, 1};
      m_in = 0; m_next = 0; m_line = 0; m_pos = 0; m_apat = 0; m_alen = 1;
    end else begin
      if (bol && m_in == 0) begin
        m_in = 1; m_line = m_next; m_next = 1 - m_next;
        m_apat = m_pat[m_line]; m_alen = m_len[m_line]; m_pos = 0;
      end else if (m_in == 1 && !bol) begin
        m_in = 0;
      end else if (m_in == 1 && px_ready) begin
        m_pos = (m_pos + 1) % m_alen;
      end
      if (cfg_wr_en) begin
        if (cfg_wr_addr == 2'd0) m_pat[0] = cfg_wr_data;
        else if (cfg_wr_addr == 2'd1) m_pat[1] = cfg_wr_data;
        else if (cfg_wr_addr == 2'd2) begin
          m_len[0] = (cfg_wr_data & 3) + 1;
          m_len[1] = ((cfg_wr_data >> 2) & 3) + 1;
        end
      end
    end
  endtask

  task automatic compare(input string req);
    int ev, es;
    ev = (m_in == 1 && bol) ? 1 : 0;
    checks++;
    if (px_valid !== ev[0]) begin
      fails++;
      $display("FAIL %s valid: got %0b expected %0d", req, px_valid, ev);
    end
    if (ev == 1) begin
      es = (m_apat >> (2 * m_pos)) & 3;
      checks++;
      if (px_sel !== es[1:0]) begin
        fails++;
        $display("FAIL %s sel: got %0d expected %0d", req, px_sel, es);
      end
      checks++;
      if (px_gain_addr !== 4'(es + 1) || px_offset_addr !== 4'(es + 5)) begin
        fails++;
        $display("FAIL %s addr: got %0d/%0d expected %0d/%0d", req,
                 px_gain_addr, px_offset_addr, es + 1, es + 5);
      end
      checks++;
      if (px_line !== m_line[0]) begin
        fails++;
        $display("FAIL %s line: got %0b expected %0d", req, px_line, m_line);
      end
    end
  endtask

  task automatic tick(input string req);
    #1;
    compare(req);
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic [1:0] a, input logic [7:0] d, input string req);
    cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
    tick(req);
    cfg_wr_en = 1'b0;
  endtask

  // stall_mask: pixel i has ready low when bit (i % 8) set; wr_at: pixel index for a write
  task automatic run_line(input int n, input logic [7:0] stall_mask, input int wr_at,
                          input logic [1:0] wa, input logic [7:0] wd, input string req);
    bol = 1'b1;
    for (int i = 0; i < n; i++) begin
      px_ready = !stall_mask[i % 8];
      if (i == wr_at) begin
        cfg_wr_en = 1'b1; cfg_wr_addr = wa; cfg_wr_data = wd;
      end
      tick(req);
      cfg_wr_en = 1'b0;
    end
    px_ready = 1'b1;
    bol = 1'b0;
    tick(req);
    tick(req);
  endtask

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) tick("R1 reset");
    rst_n = 1'b1;
    tick("R1 idle");
    // R1: a line with all-zero staging repeats selector 0 on line 0
    run_line(4, 8'h00, -1, 2'd0, 8'd0, "R1 first line");
    // R2 R3 R4: line0 = {_,_,2,1}, line1 = {1,2,0,3}, lengths 2 and 4
    write_cfg(2'd0, 8'hF9, "R2 line0");
    write_cfg(2'd1, 8'h63, "R2 line1");
    write_cfg(2'd2, 8'h0D, "R4 length");
    run_line(9, 8'h00, -1, 2'd0, 8'd0, "R3 R5 line1 wrap4");
    run_line(9, 8'h00, -1, 2'd0, 8'd0, "R4 R7 line0 wrap2");
    // R9: back-pressure on line 1
    run_line(14, 8'b1011_0010, -1, 2'd0, 8'd0, "R9 stall");
    // R8: mid-line write of line 0 is staged
    run_line(7, 8'h00, 3, 2'd0, 8'h1B, "R8 midline write");
    // R2: address 3 ignored
    write_cfg(2'd3, 8'hFF, "R2 ignored addr");
    run_line(6, 8'h00, 2, 2'd2, 8'h02, "R8 len write");
    run_line(8, 8'h00, -1, 2'd0, 8'd0, "R4 len3 line0");
    // R8: write on the same edge as a line start is not seen by that line
    bol = 1'b1; cfg_wr_en = 1'b1; cfg_wr_addr = 2'd1; cfg_wr_data = 8'hAA;
    tick("R8 same edge");
    cfg_wr_en = 1'b0;
    for (int i = 0; i < 5; i++) tick("R8 same edge line");
    bol = 1'b0;
    tick("R10 end");
    // R10: single low cycle ends the line, next line is line 0
    bol = 1'b1;
    for (int i = 0; i < 4; i++) tick("R10 restart");
    bol = 1'b0; tick("R10 gap");
    bol = 1'b1;
    for (int i = 0; i < 4; i++) tick("R10 R7 next");
    bol = 1'b0; tick("R6 low");
    // R4: length value 0 repeats position 0
    write_cfg(2'd2, 8'h00, "R4 len1");
    run_line(5, 8'h00, -1, 2'd0, 8'd0, "R4 len1 line");
    // R1: reset mid-stream restarts on line 0
    rst_n = 1'b0; tick("R1 reset2");
    rst_n = 1'b1; tick("R1 idle2");
    run_line(4, 8'h00, -1, 2'd0, 8'd0, "R1 line0 after reset");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule